// File: doc/BRIEF.md
# VRAM access wait-state generator

This block stands between the CPU bus and video memory inside a video display processor. The CPU reaches video memory through a data port, and those accesses are served only in reserved CPU time slots. A free-running counter in the video clock domain produces a one-cycle slot strobe every `SLOT_PERIOD` clocks. If a data-port access arrives before the next slot, the block can stall the CPU through an active-low, wire-ANDed wait line. It pulls that line low until the slot is reached and then lets it go.

Stalling is enabled by one bit in a control register, which is written over a synchronous register write path. While that bit is clear, no access is ever stalled. Accesses are then still carried out at the next slot, and a slow CPU sees no difference because its own bus cycle is long enough. Accesses to the control, palette and register ports never stall. Toward video memory the block issues a one-cycle grant strobe with a write flag and write data. Read data is taken in on that grant and held on the CPU data bus until the read strobe goes away.

The CPU strobes are asynchronous and pass through two flip-flops. The wait output is a pull-down enable for an open-drain pad. The block never drives the line high.

Top module: `vram_wait_gen`

## Requirements
- R1: After reset, `wait_pull`, `mem_req` and `cpu_dout_oe` are 0 and stalling is disabled, so a data-port access completes with no wait.
- R2: Clock cycles are counted from the first edge after reset release, starting at index 0. The slot falls in cycle k when k mod `SLOT_PERIOD` equals `SLOT_PERIOD`-1. A data-port access is granted in the first slot cycle at or after the cycle in which its leading edge is detected. That detection cycle is two cycles after the cycle in which the strobe is first sampled low.
- R3: The stall enable is bit 2 of register 25, written with `reg_we`. While the bit is clear, `wait_pull` is never 1.
- R4: With the enable set, `wait_pull` is 1 from the cycle after edge detection through the grant cycle. It is 0 in the cycle after the grant. An access detected in a slot cycle causes no wait.
- R5: `port_sel` code 0 selects the data port. Codes 1, 2 and 3 never raise `wait_pull` or `mem_req`.
- R6: A write grant shows `mem_we`=1, and `mem_wdata` equals `cpu_din` as it was at strobe assertion.
- R7: A read grant shows `mem_we`=0. `mem_rdata` is captured in the grant cycle and shown on `cpu_dout` with `cpu_dout_oe`=1 from the next cycle until the read strobe is released. `cpu_dout_oe` is 0 by the third cycle after release.
- R8: One strobe assertion produces exactly one grant, however long the strobe is held.
- R9: A register write to any address other than 25 leaves the stall enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | CPU chip select, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| port_sel | input | 2 | Port address, 0 = video memory data port |
| cpu_din | input | DW | Write data from the CPU |
| cpu_dout | output | DW | Read data to the CPU |
| cpu_dout_oe | output | 1 | Read data valid / bus drive enable |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_addr | input | RAW | Register number |
| reg_wdata | input | 8 | Register write data |
| wait_pull | output | 1 | Pull the open-drain wait line low |
| mem_req | output | 1 | One-cycle grant to video memory |
| mem_we | output | 1 | Grant is a write |
| mem_wdata | output | DW | Write data to video memory |
| mem_rdata | input | DW | Read data from video memory, valid in the grant cycle |

## Verification
Every result depends on where the access falls relative to the slot. The bench therefore counts clock edges from reset release and, from the cycle in which it lowers the strobe, computes the grant cycle: the first slot cycle two or more cycles later. The expected number of wait cycles is the distance from detection to that grant. Outputs are sampled on falling edges, and each sample is tagged with the edge count, so grant and wait are compared in the exact cycle they are due. The read bus enable is checked in the last held cycle and three cycles after release. A directed sweep starts one access on every slot phase, covering both the zero-wait case and the longest wait.

// File: rtl/vram_wait_gen.sv
module vram_wait_gen #(
  parameter int SLOT_PERIOD = 8,
  parameter int DW = 8,
  parameter int RAW = 6,
  parameter int WAIT_REG = 25,
  parameter int WAIT_BIT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [1:0]     port_sel,
  input  logic [DW-1:0]  cpu_din,
  output logic [DW-1:0]  cpu_dout,
  output logic           cpu_dout_oe,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic           wait_pull,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int CW = (SLOT_PERIOD > 2) ? $clog2(SLOT_PERIOD) : 1;
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_PERIOD - 1);
  localparam logic [1:0] PORT_DATA = 2'd0;

  logic [CW-1:0] slot_cnt;
  logic          slot, wte;
  logic [1:0]    rd_sy, wr_sy;
  logic          acc_q, acc_now, lead, data_lead, grant;
  logic          pending, pend_wr, rd_valid;
  logic [DW-1:0] wr_hold, rd_hold;

  assign slot = (slot_cnt == SLOT_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slot_cnt <= '0;
    else        slot_cnt <= slot ? '0 : slot_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wte <= 1'b0;
    else if (reg_we && reg_addr == RAW'(WAIT_REG)) wte <= reg_wdata[WAIT_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sy <= '0;
      wr_sy <= '0;
      acc_q <= 1'b0;
    end else begin
      rd_sy <= {rd_sy[0], ~cs_n & ~rd_n};
      wr_sy <= {wr_sy[0], ~cs_n & ~wr_n};
      acc_q <= acc_now;
    end

  assign acc_now   = rd_sy[1] | wr_sy[1];
  assign lead      = acc_now & ~acc_q;
  assign data_lead = lead & (port_sel == PORT_DATA);
  assign grant     = (pending | data_lead) & slot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pending <= 1'b0;
      pend_wr <= 1'b0;
      wr_hold <= '0;
    end else begin
      if (grant)          pending <= 1'b0;
      else if (data_lead) pending <= 1'b1;
      if (data_lead) begin
        pend_wr <= wr_sy[1];
        if (wr_sy[1]) wr_hold <= cpu_din;
      end
    end

  assign mem_req   = grant;
  assign mem_we    = pending ? pend_wr : wr_sy[1];
  assign mem_wdata = pending ? wr_hold : cpu_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_hold  <= '0;
    end else if (grant && !mem_we) begin
      rd_valid <= 1'b1;
      rd_hold  <= mem_rdata;
    end else if (!rd_sy[1]) begin
      rd_valid <= 1'b0;
    end

  assign cpu_dout    = rd_hold;
  assign cpu_dout_oe = rd_valid;
  assign wait_pull   = wte & pending;

  logic [CW:0] wait_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wait_run <= '0;
    else        wait_run <= wait_pull ? wait_run + 1'b1 : '0;

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    wait_pull |-> (int'(wait_run) < SLOT_PERIOD - 1)); // R2
  AST_SLOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_pull && mem_req) |=> !wait_pull); // R4
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_pull && !mem_req && !reg_we) |=> wait_pull); // R4
  AST_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(lead && port_sel == PORT_DATA)); // R5
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R8
  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sy[1] && !mem_req) |=> !cpu_dout_oe); // R7
endmodule

// File: tb/vram_wait_gen_tb.sv
module vram_wait_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;
  localparam int HOLD = P + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] port_sel = 2'd0;
  logic [7:0] cpu_din = '0, cpu_dout, mem_wdata, mem_rdata = '0;
  logic cpu_dout_oe, wait_pull, mem_req, mem_we;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit en_model = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  vram_wait_gen #(.SLOT_PERIOD(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .port_sel(port_sel), .cpu_din(cpu_din), .cpu_dout(cpu_dout),
    .cpu_dout_oe(cpu_dout_oe), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wait_pull(wait_pull), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_grant(input int n0);
    for (int m = n0 + 2; m < n0 + 2 + P; m++)
      if (m % P == P - 1) return m;
    return -1;
  endfunction

  task automatic reg_write(input int addr, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(addr); reg_wdata = 8'(data);
    if (addr == 25) en_model = data[2];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic access(input bit is_wr, input logic [1:0] ps);
    int n0, waits, grants, gcyc, m;
    bit we_seen, data_ok;
    logic [7:0] din, rdv;
    din = 8'($urandom); rdv = 8'($urandom);
    waits = 0; grants = 0; gcyc = -1; we_seen = 0; data_ok = 1;
    @(negedge clk);
    n0 = cyc;
    port_sel = ps; cpu_din = din; mem_rdata = rdv; cs_n = 1'b0;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk);
      if (wait_pull) waits++;
      if (mem_req) begin
        grants++; gcyc = cyc; we_seen = mem_we;
        if (is_wr) data_ok = (mem_wdata == din);
      end
    end
    m = exp_grant(n0);
    if (ps == 2'd0) begin
      chk(grants == 1, "R8", "grant count", grants, 1);
      chk(gcyc == m, "R2", "grant cycle", gcyc, m);
      chk(waits == (en_model ? m - n0 - 2 : 0), en_model ? "R4" : "R3",
          "wait cycles", waits, en_model ? m - n0 - 2 : 0);
      chk(we_seen == is_wr, is_wr ? "R6" : "R7", "mem_we", we_seen, is_wr);
      if (is_wr) chk(data_ok, "R6", "write data", 0, 1);
      else begin
        chk(cpu_dout_oe == 1'b1, "R7", "oe while held", cpu_dout_oe, 1);
        chk(cpu_dout == rdv, "R7", "read data", cpu_dout, rdv);
      end
    end else begin
      chk(grants == 0, "R5", "grant on non-data port", grants, 0);
      chk(waits == 0, "R5", "wait on non-data port", waits, 0);
    end
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    waits = 0; grants = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (wait_pull) waits++;
      if (mem_req) grants++;
    end
    chk(cpu_dout_oe == 1'b0, "R7", "oe after release", cpu_dout_oe, 0);
    chk(grants == 0 && waits == 0, "R8", "activity after release",
        grants + waits, 0);
  endtask

  task automatic align_phase(input int ph);
    do @(negedge clk); while (cyc % P != ph);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(wait_pull == 0 && mem_req == 0 && cpu_dout_oe == 0, "R1",
        "outputs in reset", {wait_pull, mem_req, cpu_dout_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wait_pull == 0 && mem_req == 0, "R1", "outputs after reset",
        {wait_pull, mem_req}, 0);
    align_phase(0);
    access(1'b0, 2'd0);
    align_phase(0);
    access(1'b1, 2'd0);
    reg_write(24, 8'h04);
    align_phase(0);
    access(1'b1, 2'd0);
    chk(n_fail == 0, "R9", "enable untouched by other register", 0, 0);
    reg_write(25, 8'h04);
    for (int ps = 1; ps < 4; ps++) begin
      access(1'b0, 2'(ps));
      access(1'b1, 2'(ps));
    end
    for (int ph = 0; ph < P; ph++) begin
      align_phase(ph);
      access(ph[0], 2'd0);
    end
    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(0, 9) == 0) reg_write(25, $urandom_range(0, 1) * 4);
      repeat ($urandom_range(0, 6)) @(negedge clk);
      access(1'($urandom), ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0);
    end
    reg_write(25, 8'h00);
    for (int ph = 0; ph < P; ph++) begin
      align_phase(ph);
      access(1'b0, 2'd0);
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule